// File: doc/BRIEF.md
# Flash Host Bus Front End with Power Control

This block sits between a host bus and the 16-bit storage array of a 1M×16 / 2M×8 flash memory model. It merges two active-low chip selects into a single enable. It accepts either 8-bit or 16-bit host transfers and maps them onto word addresses and byte-lane strobes. It also sequences the power states of the part: deep power-down, wake-up recovery, standby and active.

Driving the power-down pin low aborts the write state machine and holds every status register cleared (the compatible register, the global register and all per-block registers). When the pin is released, a recovery interval of 550 ns is counted in clock cycles, and the data bus stays off until that interval ends. The busy signal from the write state machine reaches an open-drain ready/busy pin, modelled here as a pull-down enable. Several devices can therefore share one wired line.

Top module: `flash_host_front`

## Requirements
- R1: The array is accessed and the data bus is driven only while both `ce_a_n` and `ce_b_n` are low. Raising either one removes `dq_oe`, `arr_rd` and `arr_wr` in the same cycle.
- R2: `pwr_state` encodes the power state as 0 = deep power-down, 1 = recovery, 2 = standby, 3 = active. Outside deep power-down and recovery, the state one cycle after a clock edge is 2 if either chip enable was high at that edge, and 3 if both were low.
- R3: A clock edge that samples `pd_n` low puts the block in state 0 on the next cycle, from any state. `wsm_reset` and `stat_clr` are both 1 for every cycle spent in state 0.
- R4: After `pd_n` is sampled high in state 0, the block spends exactly ceil(RECOV_PS / CLK_PS) cycles in state 1 (55 cycles at the defaults). `data_valid` is 0 in states 0 and 1 and is 1 in states 2 and 3.
- R5: `dq_oe`, `arr_rd` and `arr_wr` are 0 in states 0, 1 and 2.
- R6: When `bus_wide` is 0 (8-bit mode), a read with `addr[0]` = 0 returns array bits 7:0 on `dq_out[7:0]`, and `addr[0]` = 1 returns bits 15:8. `dq_out[15:8]` is 0 in this mode.
- R7: In 8-bit mode a write sets `arr_lane` to 2'b01 when `addr[0]` = 0 and to 2'b10 when `addr[0]` = 1. `arr_wdata` carries `dq_in[7:0]` on both byte lanes.
- R8: When `bus_wide` is 1 (16-bit mode), `arr_lane` is 2'b11, `arr_wdata` equals `dq_in`, a read returns all 16 array bits, and `addr[0]` has no effect.
- R9: `arr_addr` equals `addr[20:1]` in both modes.
- R10: `rb_pull_low` is 1 exactly when `wsm_busy` is 1 and the block is not in state 0. In state 0 the pin is released whatever `wsm_busy` is.
- R11: While `rst_n` is low the block is held in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_a_n | input | 1 | First chip enable, active low |
| ce_b_n | input | 1 | Second chip enable, active low |
| pd_n | input | 1 | Power-down / reset pin, active low |
| bus_wide | input | 1 | 1 = 16-bit transfers, 0 = 8-bit transfers |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 21 | Host byte address |
| dq_in | input | 16 | Host write data |
| dq_out | output | 16 | Host read data |
| dq_oe | output | 1 | Host data bus drive enable |
| arr_addr | output | 20 | Array word address |
| arr_rd | output | 1 | Array read strobe |
| arr_wr | output | 1 | Array write strobe |
| arr_lane | output | 2 | Array byte-lane write strobes |
| arr_wdata | output | 16 | Array write data |
| arr_rdata | input | 16 | Array read data |
| wsm_busy | input | 1 | Busy flag from the write state machine |
| wsm_reset | output | 1 | Abort/reset to the write state machine |
| stat_clr | output | 1 | Clear for all status registers |
| rb_pull_low | output | 1 | Ready/busy open-drain pull-down enable |
| data_valid | output | 1 | Outputs valid (recovery finished) |
| pwr_state | output | 2 | Power state code |

## Verification
Lane mapping is driven with an array word whose two bytes differ (0xA55A). Reads at `addr[0]` = 0 and at `addr[0]` = 1 must then return different bytes, and a swapped byte select shows up at once. Word mode is run with the same address at both values of `addr[0]` to show that the bit is ignored. Writes use a data word whose upper byte differs from its lower byte, which exposes a missing byte replication. The chip enables are driven through all four combinations, the busy input is toggled both in and out of deep power-down, and the recovery window is measured edge by edge so that an off-by-one count is caught.

// File: rtl/fhpc_pkg.sv
package fhpc_pkg;

  typedef enum logic [1:0] {
    PW_DEEP = 2'd0,
    PW_WAKE = 2'd1,
    PW_IDLE = 2'd2,
    PW_RUN  = 2'd3
  } pw_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/fhpc_power.sv
module fhpc_power
  import fhpc_pkg::*;
#(
  parameter int REC_CYC = 55
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_n,
  input  logic      chip_en,
  output pw_state_e state
);

  localparam int CNT_W = (REC_CYC < 2) ? 1 : $clog2(REC_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REC_CYC - 1);

  pw_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      PW_DEEP: if (pd_n) state_d = PW_WAKE;
      PW_WAKE: begin
        if (!pd_n)             state_d = PW_DEEP;
        else if (cnt_q == '0)  state_d = chip_en ? PW_RUN : PW_IDLE;
      end
      default: begin
        if (!pd_n) state_d = PW_DEEP;
        else       state_d = chip_en ? PW_RUN : PW_IDLE;
      end
    endcase
  end

  // recovery counter: loaded while asleep, counts down while waking
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (state_q == PW_DEEP) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (state_q == PW_WAKE && cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PW_DEEP;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_LOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state = state_q;

  // R3
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> state_q == PW_DEEP);

  // R4
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_WAKE && cnt_q != '0 && pd_n) |=> state_q == PW_WAKE);

  // R4
  wake_from_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_WAKE) |-> ($past(state_q) inside {PW_DEEP, PW_WAKE}));

endmodule

// File: rtl/fhpc_lane_map.sv
module fhpc_lane_map #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_ok,
  input  logic              bus_wide,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-2:0] arr_addr,
  output logic              arr_rd,
  output logic              arr_wr,
  output logic [DATA_W/8-1:0] arr_lane,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam int LANES = DATA_W / 8;
  localparam int SEL_W = (LANES < 2) ? 1 : $clog2(LANES);

  logic [SEL_W-1:0] byte_sel;
  logic [7:0]       rd_byte;

  assign byte_sel = addr[SEL_W-1:0];
  assign arr_addr = addr[ADDR_W-1:1];

  assign arr_rd = access_ok && !oe_n && we_n;
  assign arr_wr = access_ok && !we_n;
  assign dq_oe  = arr_rd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign arr_lane[g]      = bus_wide || (byte_sel == SEL_W'(g));
    assign arr_wdata[g*8 +: 8] = bus_wide ? host_wdata[g*8 +: 8] : host_wdata[7:0];
  end

  assign rd_byte = arr_rdata[byte_sel*8 +: 8];
  assign dq_out  = bus_wide ? arr_rdata : {{(DATA_W-8){1'b0}}, rd_byte};

  // R7
  byte_lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && !bus_wide) |-> $countones(arr_lane) == 1);

  // R8
  word_lane_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && bus_wide) |-> $countones(arr_lane) == LANES);

  // R6
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !bus_wide) |-> dq_out[DATA_W-1:8] == '0);

endmodule

// File: rtl/fhpc_rdy.sv
module fhpc_rdy (
  input  logic in_deep,
  input  logic wsm_busy,
  output logic pull_low
);

  assign pull_low = wsm_busy && !in_deep;

endmodule

// File: rtl/flash_host_front.sv
module flash_host_front
  import fhpc_pkg::*;
#(
  parameter int CLK_PS   = 10000,
  parameter int RECOV_PS = 550000,
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_a_n,
  input  logic                ce_b_n,
  input  logic                pd_n,
  input  logic                bus_wide,
  input  logic                oe_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dq_in,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe,
  output logic [ADDR_W-2:0]   arr_addr,
  output logic                arr_rd,
  output logic                arr_wr,
  output logic [DATA_W/8-1:0] arr_lane,
  output logic [DATA_W-1:0]   arr_wdata,
  input  logic [DATA_W-1:0]   arr_rdata,
  input  logic                wsm_busy,
  output logic                wsm_reset,
  output logic                stat_clr,
  output logic                rb_pull_low,
  output logic                data_valid,
  output logic [1:0]          pwr_state
);

  localparam int REC_CYC = ceil_div(RECOV_PS, CLK_PS);

  logic      rst_meta_q, rst_sync_q;
  logic      chip_en;
  pw_state_e state;
  logic      in_deep;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign chip_en = !ce_a_n && !ce_b_n;

  fhpc_power #(.REC_CYC(REC_CYC)) u_power (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .pd_n    (pd_n),
    .chip_en (chip_en),
    .state   (state)
  );

  assign in_deep    = (state == PW_DEEP);
  assign wsm_reset  = in_deep;
  assign stat_clr   = in_deep;
  assign data_valid = (state == PW_IDLE) || (state == PW_RUN);
  assign pwr_state  = state;

  fhpc_lane_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .access_ok  ((state == PW_RUN) && chip_en),
    .bus_wide   (bus_wide),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .addr       (addr),
    .host_wdata (dq_in),
    .arr_rdata  (arr_rdata),
    .arr_addr   (arr_addr),
    .arr_rd     (arr_rd),
    .arr_wr     (arr_wr),
    .arr_lane   (arr_lane),
    .arr_wdata  (arr_wdata),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
  );

  fhpc_rdy u_rdy (
    .in_deep  (in_deep),
    .wsm_busy (wsm_busy),
    .pull_low (rb_pull_low)
  );

  // R1
  dual_enable_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (dq_oe || arr_wr) |-> (!ce_a_n && !ce_b_n));

  // R5
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pwr_state != 2'd3) |-> (!dq_oe && !arr_rd && !arr_wr));

  // R10
  rb_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pwr_state == 2'd0) |-> !rb_pull_low);

  // R4
  valid_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(data_valid) |-> $past(pwr_state) == 2'd1);

endmodule

// File: tb/flash_host_front_test.sv
`timescale 1ns/1ps
module flash_host_front_test;

  localparam int REC = 55;

  logic        clk = 1'b0;
  logic        rst_n, ce_a_n, ce_b_n, pd_n, bus_wide, oe_n, we_n, wsm_busy;
  logic [20:0] addr;
  logic [15:0] dq_in, arr_rdata;
  logic [15:0] dq_out, arr_wdata;
  logic        dq_oe, arr_rd, arr_wr, wsm_reset, stat_clr, rb_pull_low, data_valid;
  logic [19:0] arr_addr;
  logic [1:0]  arr_lane, pwr_state;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  flash_host_front uut (
    .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .pd_n(pd_n),
    .bus_wide(bus_wide), .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .arr_addr(arr_addr), .arr_rd(arr_rd),
    .arr_wr(arr_wr), .arr_lane(arr_lane), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata), .wsm_busy(wsm_busy), .wsm_reset(wsm_reset),
    .stat_clr(stat_clr), .rb_pull_low(rb_pull_low), .data_valid(data_valid),
    .pwr_state(pwr_state)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce_a_n = 1'b1; ce_b_n = 1'b1; pd_n = 1'b1; bus_wide = 1'b1;
    oe_n = 1'b1; we_n = 1'b1; wsm_busy = 1'b0; addr = '0; dq_in = '0;
    arr_rdata = 16'hA55A;
    repeat (3) tick();
    chk(pwr_state == 2'd0, "R11 state in reset", pwr_state, 0);
    chk(data_valid == 1'b0, "R4 valid in reset", data_valid, 0);
    pd_n = 1'b0;
    rst_n = 1'b1;
    repeat (4) tick();
    chk(pwr_state == 2'd0 && stat_clr && wsm_reset, "R3 deep holds clears",
        {pwr_state, stat_clr, wsm_reset}, 32'h3);
  endtask

  // leave deep power-down and measure the recovery window
  task automatic t_wake(input bit enabled);
    int valid_at;
    ce_a_n = !enabled; ce_b_n = !enabled;
    pd_n = 1'b1;
    tick();
    chk(pwr_state == 2'd1, "R4 enter recovery", pwr_state, 1);
    chk(!dq_oe && !data_valid, "R5 quiet in recovery", {dq_oe, data_valid}, 0);
    valid_at = -1;
    for (int i = 1; i <= REC + 2; i++) begin
      tick();
      if (data_valid && valid_at < 0) valid_at = i;
    end
    chk(valid_at == REC, "R4 recovery length", valid_at, REC);
    chk(pwr_state == (enabled ? 2'd3 : 2'd2), "R2 state after recovery",
        pwr_state, enabled ? 3 : 2);
  endtask

  task automatic t_enables();
    bus_wide = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = 21'h000100;
    for (int k = 0; k < 4; k++) begin
      ce_a_n = k[0]; ce_b_n = k[1];
      tick();
      chk(pwr_state == ((k == 0) ? 2'd3 : 2'd2), "R2 state per enables",
          pwr_state, (k == 0) ? 3 : 2);
      chk(dq_oe == (k == 0), "R1 bus drive per enables", dq_oe, k == 0);
    end
    ce_a_n = 1'b0; ce_b_n = 1'b0;
    tick();
    ce_b_n = 1'b1;
    #1;
    chk(!dq_oe && !arr_rd, "R1 same-cycle disable", {dq_oe, arr_rd}, 0);
    ce_b_n = 1'b0;
    tick();
    chk(data_valid == 1'b1, "R4 valid when active", data_valid, 1);
    oe_n = 1'b1;
  endtask

  task automatic t_byte_read();
    bus_wide = 1'b0; oe_n = 1'b0; we_n = 1'b1; arr_rdata = 16'hA55A;
    addr = 21'h0ABC4; #1;
    chk(dq_oe && dq_out == 16'h005A, "R6 low byte read", dq_out, 16'h005A);
    chk(arr_addr == 20'h055E2, "R9 byte-mode address", arr_addr, 20'h055E2);
    addr = 21'h0ABC5; #1;
    chk(dq_out == 16'h00A5, "R6 high byte read", dq_out, 16'h00A5);
    chk(arr_addr == 20'h055E2, "R9 A0 not in word address", arr_addr, 20'h055E2);
    oe_n = 1'b1;
  endtask

  task automatic t_byte_write();
    bus_wide = 1'b0; oe_n = 1'b1; we_n = 1'b0; dq_in = 16'h3C96;
    addr = 21'h1FFFFE; #1;
    chk(arr_wr && arr_lane == 2'b01, "R7 lane for A0=0", arr_lane, 2'b01);
    chk(arr_wdata == 16'h9696, "R7 byte replicated", arr_wdata, 16'h9696);
    addr = 21'h1FFFFF; #1;
    chk(arr_lane == 2'b10, "R7 lane for A0=1", arr_lane, 2'b10);
    chk(arr_addr == 20'hFFFFF, "R9 top address", arr_addr, 20'hFFFFF);
    we_n = 1'b1;
  endtask

  task automatic t_word();
    bus_wide = 1'b1; oe_n = 1'b1; we_n = 1'b0; dq_in = 16'h3C96;
    for (int a0 = 0; a0 < 2; a0++) begin
      addr = 21'h012340 | a0; #1;
      chk(arr_lane == 2'b11 && arr_wdata == 16'h3C96, "R8 word write",
          {arr_lane, arr_wdata}, {2'b11, 16'h3C96});
      chk(arr_addr == 20'h091A0, "R9 word address A0 ignored", arr_addr, 20'h091A0);
    end
    we_n = 1'b1; oe_n = 1'b0; arr_rdata = 16'hA55A;
    for (int a0 = 0; a0 < 2; a0++) begin
      addr = 21'h012340 | a0; #1;
      chk(dq_out == 16'hA55A, "R8 word read A0 ignored", dq_out, 16'hA55A);
    end
    oe_n = 1'b1;
  endtask

  task automatic t_busy_and_deep();
    wsm_busy = 1'b1; #1;
    chk(rb_pull_low == 1'b1, "R10 busy pulls low", rb_pull_low, 1);
    wsm_busy = 1'b0; #1;
    chk(rb_pull_low == 1'b0, "R10 ready floats", rb_pull_low, 0);
    wsm_busy = 1'b1; oe_n = 1'b0; pd_n = 1'b0;
    tick();
    chk(pwr_state == 2'd0, "R3 deep entry", pwr_state, 0);
    chk(stat_clr && wsm_reset, "R3 abort and clear", {stat_clr, wsm_reset}, 3);
    chk(rb_pull_low == 1'b0, "R10 busy ignored in deep", rb_pull_low, 0);
    chk(!dq_oe && !data_valid, "R5 bus off in deep", {dq_oe, data_valid}, 0);
    oe_n = 1'b1; wsm_busy = 1'b0;
    tick();
  endtask

  initial begin
    t_reset();
    t_wake(1'b0);
    t_enables();
    t_byte_read();
    t_byte_write();
    t_word();
    t_busy_and_deep();
    t_wake(1'b1);
    chk(!stat_clr && !wsm_reset, "R3 clear released after wake",
        {stat_clr, wsm_reset}, 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule